// File: doc/BRIEF.md
# Speculative and Architectural Register Files

This block holds two copies of a processor's register state for a pipeline whose instructions finish out of order. The front copy is speculative. Decode reads its operands only from the front copy. A completing result is written there at once, provided it comes from the newest writer of its destination. The back copy is architectural. It changes only through a retire port, which the retirement queue drives in program order. No search of the retirement queue is ever needed to find an operand.

Each front entry carries a valid flag and one word. While the entry is valid, the word is the register value. While it is pending, the word is the producer's tag, zero-extended. When decode names a destination, that entry becomes pending on the new tag. A completion writes an entry only when the entry is pending on that exact tag. When a retiring instruction carries an exception, the whole back copy is loaded into the front copy in one cycle and every front entry becomes valid.

Top module: `specarch_regfile`

## Requirements
- R1: After reset every front entry reads valid with value 0, and every back entry holds 0.
- R2: A decode rename (`dec_we`) makes the destination entry read pending from the next cycle, with the new tag in the low bits of the word and zeros above it.
- R3: A completion whose tag equals the pending entry's tag writes the data and makes the entry valid from the next cycle.
- R4: A completion whose tag differs from the stored tag, or that targets a valid entry, has no effect on the front copy.
- R5: If a completion is accepted in the same cycle as a read of its register, the read returns the completing data as valid in that cycle.
- R6: A retire without an exception writes `ret_data` into the back entry `ret_dst`. A retire with an exception does not write the back copy.
- R7: A retire with an exception loads every front entry from the back copy and makes all of them valid from the next cycle. A rename or completion in that cycle is dropped.
- R8: If a rename and an accepted completion target the same register in one cycle, the rename wins: the entry ends up pending on the new tag. A read in the rename cycle returns the state from before the rename.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_a | input | IDX_W | Operand A register index |
| src_b | input | IDX_W | Operand B register index |
| rd_a_val | output | 1 | Operand A is a value (1) or a tag (0) |
| rd_a_word | output | DATA_W | Operand A value or pending tag |
| rd_b_val | output | 1 | Operand B is a value (1) or a tag (0) |
| rd_b_word | output | DATA_W | Operand B value or pending tag |
| dec_we | input | 1 | Rename a destination this cycle |
| dec_dst | input | IDX_W | Destination register being renamed |
| dec_tag | input | TAG_W | Tag of the new producer |
| cmp_valid | input | 1 | A result completes this cycle |
| cmp_dst | input | IDX_W | Destination of the completing result |
| cmp_tag | input | TAG_W | Tag of the completing producer |
| cmp_data | input | DATA_W | Completing result |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_dst | input | IDX_W | Destination of the retiring instruction |
| ret_data | input | DATA_W | Result of the retiring instruction |
| ret_exc | input | 1 | The retiring instruction has an exception |

## Verification
A front entry that is wrongly left pending, or wrongly marked valid, shows up at the read ports as a wrong `rd_*_val` bit on the first cycle the register is named. A stale completion that is wrongly accepted shows up as the wrong value on the next read. A corrupted back copy stays hidden until a recovery. The first read after that recovery exposes it. For this reason the bench retires values, forces an exception, and then reads every affected register.

// File: rtl/specarch_regfile.sv
module specarch_regfile #(
  parameter int NREG   = 8,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  src_a,
  input  logic [IDX_W-1:0]  src_b,
  output logic              rd_a_val,
  output logic [DATA_W-1:0] rd_a_word,
  output logic              rd_b_val,
  output logic [DATA_W-1:0] rd_b_word,
  input  logic              dec_we,
  input  logic [IDX_W-1:0]  dec_dst,
  input  logic [TAG_W-1:0]  dec_tag,
  input  logic              cmp_valid,
  input  logic [IDX_W-1:0]  cmp_dst,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic [DATA_W-1:0] cmp_data,
  input  logic              ret_valid,
  input  logic [IDX_W-1:0]  ret_dst,
  input  logic [DATA_W-1:0] ret_data,
  input  logic              ret_exc
);

  logic [NREG-1:0]             fvld;
  logic [NREG-1:0][DATA_W-1:0] fword;
  logic [NREG-1:0][DATA_W-1:0] aword;

  wire recover = ret_valid & ret_exc;
  wire cmp_hit = cmp_valid & ~fvld[cmp_dst] & (fword[cmp_dst][TAG_W-1:0] == cmp_tag);
  wire fwd_a   = cmp_hit & (cmp_dst == src_a);
  wire fwd_b   = cmp_hit & (cmp_dst == src_b);

  assign rd_a_val  = fvld[src_a] | fwd_a;
  assign rd_a_word = fwd_a ? cmp_data : fword[src_a];
  assign rd_b_val  = fvld[src_b] | fwd_b;
  assign rd_b_word = fwd_b ? cmp_data : fword[src_b];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fvld  <= '1;
      fword <= '0;
      aword <= '0;
    end else begin
      if (ret_valid && !ret_exc) aword[ret_dst] <= ret_data;
      if (recover) begin
        fword <= aword;
        fvld  <= '1;
      end else begin
        if (cmp_hit) begin
          fword[cmp_dst] <= cmp_data;
          fvld[cmp_dst]  <= 1'b1;
        end
        if (dec_we) begin
          fword[dec_dst] <= DATA_W'(dec_tag);
          fvld[dec_dst]  <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/specarch_regfile_chk.sv
module specarch_regfile_chk #(
  parameter int NREG   = 8,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [IDX_W-1:0]            src_a,
  input logic                        rd_a_val,
  input logic [DATA_W-1:0]           rd_a_word,
  input logic                        rd_b_val,
  input logic                        dec_we,
  input logic [IDX_W-1:0]            dec_dst,
  input logic                        cmp_valid,
  input logic [IDX_W-1:0]            cmp_dst,
  input logic [TAG_W-1:0]            cmp_tag,
  input logic [DATA_W-1:0]           cmp_data,
  input logic                        ret_valid,
  input logic [IDX_W-1:0]            ret_dst,
  input logic [DATA_W-1:0]           ret_data,
  input logic                        ret_exc,
  input logic [NREG-1:0]             fvld,
  input logic [NREG-1:0][DATA_W-1:0] fword,
  input logic [NREG-1:0][DATA_W-1:0] aword
);

  assert_rename_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_we && !(ret_valid && ret_exc) |=> !fvld[$past(dec_dst)]);

  assert_stale_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && fvld[cmp_dst] && !(ret_valid && ret_exc) && !(dec_we && dec_dst == cmp_dst)
    |=> fvld[$past(cmp_dst)] && fword[$past(cmp_dst)] == $past(fword[cmp_dst]));

  assert_forward_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && !fvld[cmp_dst] && fword[cmp_dst][TAG_W-1:0] == cmp_tag && src_a == cmp_dst
    |-> rd_a_val && rd_a_word == cmp_data);

  assert_retire_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && !ret_exc |=> aword[$past(ret_dst)] == $past(ret_data));

  assert_recover_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && ret_exc |=> rd_a_val && rd_b_val && fvld == '1);

endmodule

bind specarch_regfile specarch_regfile_chk #(.NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_a(src_a), .rd_a_val(rd_a_val), .rd_a_word(rd_a_word),
  .rd_b_val(rd_b_val), .dec_we(dec_we), .dec_dst(dec_dst), .cmp_valid(cmp_valid),
  .cmp_dst(cmp_dst), .cmp_tag(cmp_tag), .cmp_data(cmp_data), .ret_valid(ret_valid),
  .ret_dst(ret_dst), .ret_data(ret_data), .ret_exc(ret_exc), .fvld(fvld),
  .fword(fword), .aword(aword)
);

// File: tb/specarch_regfile_tb.sv
module specarch_regfile_tb;
  localparam int NREG = 8, DATA_W = 16, TAG_W = 4, IDX_W = 3;

  logic clk = 0, rst_n = 0;
  logic [IDX_W-1:0] src_a, src_b, dec_dst, cmp_dst, ret_dst;
  logic rd_a_val, rd_b_val, dec_we, cmp_valid, ret_valid, ret_exc;
  logic [DATA_W-1:0] rd_a_word, rd_b_word, cmp_data, ret_data;
  logic [TAG_W-1:0] dec_tag, cmp_tag;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  specarch_regfile #(.NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_dut (.*);

  // kind: 0 rename, 1 complete, 2 retire, 3 read A and check
  localparam int NV = 18;
  localparam logic [42:0] VEC [NV] = '{
    {2'd3, 3'd1, 4'd0, 16'h0000, 1'b0, 1'b1, 16'h0000},
    {2'd0, 3'd1, 4'd5, 16'h0000, 1'b0, 1'b0, 16'h0000},
    {2'd3, 3'd1, 4'd0, 16'h0000, 1'b0, 1'b0, 16'h0005},
    {2'd1, 3'd1, 4'd5, 16'h1234, 1'b0, 1'b0, 16'h0000},
    {2'd3, 3'd1, 4'd0, 16'h0000, 1'b0, 1'b1, 16'h1234},
    {2'd0, 3'd2, 4'd6, 16'h0000, 1'b0, 1'b0, 16'h0000},
    {2'd0, 3'd2, 4'd7, 16'h0000, 1'b0, 1'b0, 16'h0000},
    {2'd1, 3'd2, 4'd6, 16'hAAAA, 1'b0, 1'b0, 16'h0000},
    {2'd3, 3'd2, 4'd0, 16'h0000, 1'b0, 1'b0, 16'h0007},
    {2'd1, 3'd2, 4'd7, 16'hBBBB, 1'b0, 1'b0, 16'h0000},
    {2'd3, 3'd2, 4'd0, 16'h0000, 1'b0, 1'b1, 16'hBBBB},
    {2'd1, 3'd2, 4'd7, 16'hCCCC, 1'b0, 1'b0, 16'h0000},
    {2'd3, 3'd2, 4'd0, 16'h0000, 1'b0, 1'b1, 16'hBBBB},
    {2'd2, 3'd1, 4'd0, 16'h1234, 1'b0, 1'b0, 16'h0000},
    {2'd2, 3'd2, 4'd0, 16'hBBBB, 1'b0, 1'b0, 16'h0000},
    {2'd0, 3'd1, 4'd8, 16'h0000, 1'b0, 1'b0, 16'h0000},
    {2'd1, 3'd1, 4'd8, 16'h5555, 1'b0, 1'b0, 16'h0000},
    {2'd3, 3'd1, 4'd0, 16'h0000, 1'b0, 1'b1, 16'h5555}
  };

  task automatic idle();
    dec_we = 0; cmp_valid = 0; ret_valid = 0; ret_exc = 0;
    dec_dst = 0; dec_tag = 0; cmp_dst = 0; cmp_tag = 0; cmp_data = 0;
    ret_dst = 0; ret_data = 0; src_a = 0; src_b = 0;
  endtask

  task automatic chk(string req, logic gv, logic [DATA_W-1:0] gw, logic ev, logic [DATA_W-1:0] ew);
    checks++;
    if (gv !== ev || gw !== ew) begin
      fails++;
      $display("FAIL %s: got val=%0b word=%h, expected val=%0b word=%h", req, gv, gw, ev, ew);
    end
  endtask

  task automatic rd(string req, int r, logic ev, logic [DATA_W-1:0] ew);
    @(negedge clk); idle(); src_a = IDX_W'(r); src_b = IDX_W'(r); #1;
    chk(req, rd_a_val, rd_a_word, ev, ew);
    chk(req, rd_b_val, rd_b_word, ev, ew);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state of all front entries
    for (int r = 0; r < NREG; r++) rd("R1 reset", r, 1'b1, '0);

    // table: R2 rename, R3 accept, R4 stale ignored, R6 retire
    for (int i = 0; i < NV; i++) begin
      @(negedge clk); idle();
      case (VEC[i][42:41])
        2'd0: begin dec_we = 1; dec_dst = VEC[i][40:38]; dec_tag = VEC[i][37:34]; end
        2'd1: begin cmp_valid = 1; cmp_dst = VEC[i][40:38]; cmp_tag = VEC[i][37:34]; cmp_data = VEC[i][33:18]; end
        2'd2: begin ret_valid = 1; ret_dst = VEC[i][40:38]; ret_data = VEC[i][33:18]; ret_exc = VEC[i][17]; end
        default: begin
          src_a = VEC[i][40:38]; #1;
          chk("R2/R3/R4 table", rd_a_val, rd_a_word, VEC[i][16], VEC[i][15:0]);
        end
      endcase
    end

    // R5 forwarding of an accepted completion to a same-cycle read
    @(negedge clk); idle(); dec_we = 1; dec_dst = 3; dec_tag = 9;
    @(negedge clk); idle(); cmp_valid = 1; cmp_dst = 3; cmp_tag = 9; cmp_data = 16'h7777; src_a = 3; #1;
    chk("R5 forward", rd_a_val, rd_a_word, 1'b1, 16'h7777);

    // R8 rename wins over an accepted completion; read in rename cycle sees old state
    @(negedge clk); idle(); dec_we = 1; dec_dst = 5; dec_tag = 1;
    @(negedge clk); idle(); dec_we = 1; dec_dst = 5; dec_tag = 2;
    cmp_valid = 1; cmp_dst = 5; cmp_tag = 1; cmp_data = 16'h4321; src_a = 4; src_b = 5; #1;
    chk("R8 old read", rd_b_val, rd_b_word, 1'b1, 16'h4321);
    rd("R8 rename wins", 5, 1'b0, 16'h0002);

    // R6 exception retire does not write back copy; R7 recovery
    @(negedge clk); idle(); dec_we = 1; dec_dst = 4; dec_tag = 10;
    @(negedge clk); idle(); ret_valid = 1; ret_exc = 1; ret_dst = 1; ret_data = 16'hDEAD;
    dec_we = 1; dec_dst = 6; dec_tag = 3;
    rd("R7 recover r1", 1, 1'b1, 16'h1234);
    rd("R7 recover r2", 2, 1'b1, 16'hBBBB);
    rd("R7 recover r3", 3, 1'b1, 16'h0000);
    rd("R7 recover r4", 4, 1'b1, 16'h0000);
    rd("R7 rename dropped r6", 6, 1'b1, 16'h0000);
    // R4 stale completion after recovery ignored
    @(negedge clk); idle(); cmp_valid = 1; cmp_dst = 4; cmp_tag = 10; cmp_data = 16'h9999;
    rd("R4 post-recovery", 4, 1'b1, 16'h0000);
    // R6 second recovery shows r1 unchanged by the faulting retire
    @(negedge clk); idle(); dec_we = 1; dec_dst = 1; dec_tag = 4;
    @(negedge clk); idle(); ret_valid = 1; ret_exc = 1; ret_dst = 1; ret_data = 16'hBEEF;
    rd("R6 no exc write", 1, 1'b1, 16'h1234);

    @(negedge clk); idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule